// File: doc/BRIEF.md
# Indirect Clock-Synthesizer Register Port

This block gives a host a narrow, byte-wide path into a small bank of 8-bit clock-synthesizer registers. The host never addresses those registers directly. It first writes an address byte that carries a six-bit register index and a write-enable flag. It then reads or writes a data byte, and that access goes to whichever register the index selects. The write-enable flag stays set until the host writes the address byte again. A data write lands only while the flag is set, so the usual sequence is: set the flag, write the data, then clear the flag.

The bank holds four per-clock feedback dividers at consecutive indices, one shared post-divider byte packed with four 2-bit fields, a pixel-clock control byte containing a generator reset bit, and an extended control byte. A third host byte, the clock-control register, picks which of the four pixel clocks is active and can fire a one-cycle strobe. The block drives the divider settings of the selected clock onto its outputs so that the synthesizer next to it can use them.

Host byte addresses (`host_sel`): 0 is the address byte, 1 is the data byte, 2 is clock control, and 3 is unused (it reads zero and ignores writes). Internal indices: 5 is pixel-clock control, 6 is the post-divider, 7 to 10 are the feedback dividers for clocks 0 to 3, and 11 is extended control.

Top module: `clkreg_port`

## Requirements
- R1: After reset every register is zero, the active-clock select is clock 0, `host_rdata` is 0 and `clk_strobe` is low.
- R2: A write to the address byte stores the index in bits 7:2 and the write-enable flag in bit 1. Bit 0 is reserved and always reads back as 0. Reading the address byte returns the stored byte.
- R3: A data-byte write while the write-enable flag is set updates the indexed register. A later data-byte read returns the new value.
- R4: A data-byte write while the write-enable flag is clear leaves every register unchanged.
- R5: A write to an unimplemented index is ignored, and a read of an unimplemented index returns 0.
- R6: The post-divider byte (index 6) holds the field for clock n in bits 2n+1:2n. `act_post_div` shows the field of the selected clock.
- R7: The feedback divider for clock n sits at index 7+n. `act_fb_div` shows the divider of the selected clock.
- R8: A write to clock control loads the active-clock select from bits 1:0. If bit 6 of that write is 1, `clk_strobe` is high for exactly the one cycle after the write. Reading clock control returns the select in bits 1:0 and 0 in every other bit.
- R9: Bit 2 of the pixel-clock control byte (index 5) drives `vgen_rst`.
- R10: In the extended control byte (index 11), bit 4+n is the extension bit for clock n and appears on `act_ext` while clock n is selected. Bits 3:0 appear on `ext_div`.
- R11: `host_rdata` updates on the clock edge where `host_rd` is sampled high and holds its value when no read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 2 | Host byte select: 0 address, 1 data, 2 clock control |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| pix_sel | output | 2 | Active pixel-clock select |
| clk_strobe | output | 1 | One-cycle strobe from clock control |
| vgen_rst | output | 1 | Pixel-clock generator reset |
| act_post_div | output | 2 | Post-divider field of the selected clock |
| act_fb_div | output | 8 | Feedback divider of the selected clock |
| act_ext | output | 1 | Extension bit of the selected clock |
| ext_div | output | 4 | Low nibble of extended control |

## Verification
A write takes effect on the edge that samples `host_wr`. The divider, reset and select outputs decode the registers without any further register stage, so they are correct right after that edge. A read result sits one register deep: it appears on `host_rdata` after the edge that samples `host_rd`. The strobe is also registered, so it is high for the cycle after the control write and low one cycle later. The bench drives its strobes on falling edges and samples on the next falling edge, which places every check exactly one rising edge after its stimulus. The strobe check samples two consecutive falling edges.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;
    localparam int NUM_CLK  = 4;
    localparam int IDX_W    = 6;
    localparam int SEL_W    = $clog2(NUM_CLK);
    localparam int PD_W     = 2;

    localparam logic [IDX_W-1:0] IDX_VCTL = 6'd5;
    localparam logic [IDX_W-1:0] IDX_POST = 6'd6;
    localparam logic [IDX_W-1:0] IDX_FB0  = 6'd7;
    localparam logic [IDX_W-1:0] IDX_EXT  = IDX_FB0 + IDX_W'(NUM_CLK);

    localparam int VRST_BIT   = 2;
    localparam int STROBE_BIT = 6;
    localparam int WE_BIT     = 1;

    typedef enum logic [1:0] {
        HS_ADDR = 2'd0,
        HS_DATA = 2'd1,
        HS_CTRL = 2'd2,
        HS_NONE = 2'd3
    } host_sel_e;

    typedef struct packed {
        logic [7:0]              vctl;
        logic [7:0]              post;
        logic [NUM_CLK-1:0][7:0] fb;
        logic [7:0]              ext;
    } bank_t;
endpackage

// File: rtl/clkreg_addr_dec.sv
module clkreg_addr_dec
    import clkreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_wr,
    input  logic [7:0]       wdata,
    output logic [IDX_W-1:0] idx,
    output logic             wr_en_flag,
    output logic [7:0]       addr_byte
);
    logic [7:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (addr_wr) addr_d = wdata & 8'hFE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign idx        = addr_q[7:2];
    assign wr_en_flag = addr_q[WE_BIT];
    assign addr_byte  = addr_q;

    // R2
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> (addr_byte == ($past(wdata) & 8'hFE)));
endmodule

// File: rtl/clkreg_bank.sv
module clkreg_bank
    import clkreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    input  logic [SEL_W-1:0] sel,
    output logic [7:0]       rd_val,
    output logic             idx_valid,
    output logic [PD_W-1:0]  act_post_div,
    output logic [7:0]       act_fb_div,
    output logic             act_ext,
    output logic [3:0]       ext_div,
    output logic             vgen_rst
);
    bank_t bank_d, bank_q;
    logic  is_vctl, is_post, is_ext;
    logic [NUM_CLK-1:0] is_fb;

    assign is_vctl = (idx == IDX_VCTL);
    assign is_post = (idx == IDX_POST);
    assign is_ext  = (idx == IDX_EXT);

    for (genvar n = 0; n < NUM_CLK; n++) begin : g_fb_hit
        assign is_fb[n] = (idx == IDX_FB0 + IDX_W'(n));
    end

    assign idx_valid = is_vctl | is_post | is_ext | (|is_fb);

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            if (is_vctl) bank_d.vctl = wdata;
            if (is_post) bank_d.post = wdata;
            if (is_ext)  bank_d.ext  = wdata;
            for (int n = 0; n < NUM_CLK; n++)
                if (is_fb[n]) bank_d.fb[n] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        rd_val = '0;
        if (is_vctl) rd_val = bank_q.vctl;
        if (is_post) rd_val = bank_q.post;
        if (is_ext)  rd_val = bank_q.ext;
        for (int n = 0; n < NUM_CLK; n++)
            if (is_fb[n]) rd_val = bank_q.fb[n];
    end

    assign act_post_div = bank_q.post[PD_W*sel +: PD_W];
    assign act_fb_div   = bank_q.fb[sel];
    assign act_ext      = bank_q.ext[4 + 32'(sel)];
    assign ext_div      = bank_q.ext[3:0];
    assign vgen_rst     = bank_q.vctl[VRST_BIT];

    // R4
    no_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_q));

    // R5
    bad_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !idx_valid) |=> $stable(bank_q));
endmodule

// File: rtl/clkreg_port.sv
module clkreg_port
    import clkreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [1:0]       host_sel,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic [SEL_W-1:0] pix_sel,
    output logic             clk_strobe,
    output logic             vgen_rst,
    output logic [PD_W-1:0]  act_post_div,
    output logic [7:0]       act_fb_div,
    output logic             act_ext,
    output logic [3:0]       ext_div
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             strobe;
        logic [7:0]       rdata;
    } port_t;

    port_t st_d, st_q;

    logic [IDX_W-1:0] idx;
    logic             we_flag, idx_valid;
    logic [7:0]       addr_byte, rd_val;
    logic             addr_wr, data_wr, ctrl_wr;

    assign addr_wr = host_wr && (host_sel == HS_ADDR);
    assign data_wr = host_wr && (host_sel == HS_DATA);
    assign ctrl_wr = host_wr && (host_sel == HS_CTRL);

    clkreg_addr_dec u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_wr    (addr_wr),
        .wdata      (host_wdata),
        .idx        (idx),
        .wr_en_flag (we_flag),
        .addr_byte  (addr_byte)
    );

    clkreg_bank u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (data_wr && we_flag),
        .idx          (idx),
        .wdata        (host_wdata),
        .sel          (st_q.sel),
        .rd_val       (rd_val),
        .idx_valid    (idx_valid),
        .act_post_div (act_post_div),
        .act_fb_div   (act_fb_div),
        .act_ext      (act_ext),
        .ext_div      (ext_div),
        .vgen_rst     (vgen_rst)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (ctrl_wr) begin
            st_d.sel    = host_wdata[SEL_W-1:0];
            st_d.strobe = host_wdata[STROBE_BIT];
        end
        if (host_rd) begin
            unique case (host_sel)
                HS_ADDR: st_d.rdata = addr_byte;
                HS_DATA: st_d.rdata = rd_val;
                HS_CTRL: st_d.rdata = 8'(st_q.sel);
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rdata = st_q.rdata;
    assign pix_sel    = st_q.sel;
    assign clk_strobe = st_q.strobe;

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));

    // R8
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_strobe) |-> $past(host_wr && host_sel == HS_CTRL));

    // R5
    bad_idx_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_sel == HS_DATA && !idx_valid) |=> (host_rdata == 8'h00));

    // R2
    resv_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_sel == HS_ADDR) |=> (host_rdata[0] == 1'b0));
endmodule

// File: tb/clkreg_port_tb.sv
module clkreg_port_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 0, rst_n = 0;
    logic       host_wr = 0, host_rd = 0;
    logic [1:0] host_sel = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic [1:0] pix_sel, act_post_div;
    logic       clk_strobe, vgen_rst, act_ext;
    logic [7:0] act_fb_div;
    logic [3:0] ext_div;

    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkreg_port u_dut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwr(logic [1:0] s, logic [7:0] d);
        @(negedge clk);
        host_sel = s; host_wdata = d; host_wr = 1;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic hrd(logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        host_sel = s; host_rd = 1;
        @(negedge clk);
        host_rd = 0;
        d = host_rdata;
    endtask

    task automatic reg_wr(logic [5:0] i, logic [7:0] d);
        hwr(2'd0, {i, 2'b10});
        hwr(2'd1, d);
        hwr(2'd0, {i, 2'b00});
    endtask

    task automatic reg_rd(logic [5:0] i, output logic [7:0] d);
        hwr(2'd0, {i, 2'b00});
        hrd(2'd1, d);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 rdata", host_rdata, 0);
        check("R1 pix_sel", pix_sel, 0);
        check("R1 strobe", clk_strobe, 0);
        check("R1 fb", act_fb_div, 0);
        check("R1 vgen_rst", vgen_rst, 0);
        reg_rd(6'd9, v);
        check("R1 fb2 reg", v, 0);
    endtask

    task automatic t_addr();
        logic [7:0] v;
        hwr(2'd0, 8'hFF);
        hrd(2'd0, v);
        check("R2 addr readback bit0 clear", v, 8'hFE);
        hwr(2'd0, 8'h1D);
        hrd(2'd0, v);
        check("R2 addr readback", v, 8'h1C);
    endtask

    task automatic t_write_read();
        logic [7:0] v;
        reg_wr(6'd7, 8'hA5);
        reg_rd(6'd7, v);
        check("R3 fb0 readback", v, 8'hA5);
        check("R7 act_fb clock0", act_fb_div, 8'hA5);
        reg_wr(6'd8, 8'h81);
        reg_wr(6'd9, 8'h92);
        reg_wr(6'd10, 8'hFF);
        reg_rd(6'd10, v);
        check("R3 fb3 readback", v, 8'hFF);
    endtask

    task automatic t_no_flag();
        logic [7:0] v;
        hwr(2'd0, {6'd7, 2'b00});
        hwr(2'd1, 8'h33);
        hrd(2'd1, v);
        check("R4 write without flag ignored", v, 8'hA5);
    endtask

    task automatic t_unimpl();
        logic [7:0] v;
        reg_wr(6'd12, 8'h77);
        reg_rd(6'd12, v);
        check("R5 unimplemented reads zero", v, 0);
        reg_wr(6'd0, 8'h55);
        reg_rd(6'd0, v);
        check("R5 index0 reads zero", v, 0);
        reg_rd(6'd11, v);
        check("R5 ext untouched", v, 0);
    endtask

    task automatic t_select();
        logic [7:0] v;
        reg_wr(6'd6, 8'b10_01_11_00);
        reg_wr(6'd11, 8'b0100_1010);
        for (int n = 0; n < 4; n++) begin
            hwr(2'd2, 8'(n));
            check("R8 pix_sel", pix_sel, n);
            check("R6 post field", act_post_div, (8'b10_01_11_00 >> (2*n)) & 3);
            check("R7 fb select", act_fb_div, (n == 0) ? 8'hA5 : (n == 1) ? 8'h81 :
                                              (n == 2) ? 8'h92 : 8'hFF);
            check("R10 ext bit", act_ext, (n == 2));
        end
        check("R10 ext_div", ext_div, 4'hA);
        hrd(2'd2, v);
        check("R8 ctrl readback", v, 3);
    endtask

    task automatic t_strobe();
        logic [7:0] v;
        check("R8 strobe idle", clk_strobe, 0);
        @(negedge clk);
        host_sel = 2'd2; host_wdata = 8'h41; host_wr = 1;
        @(negedge clk);
        host_wr = 0;
        check("R8 strobe high", clk_strobe, 1);
        check("R8 sel with strobe", pix_sel, 1);
        @(negedge clk);
        check("R8 strobe one cycle", clk_strobe, 0);
        hrd(2'd2, v);
        check("R8 strobe reads zero", v, 1);
    endtask

    task automatic t_vrst();
        reg_wr(6'd5, 8'h04);
        check("R9 vgen_rst set", vgen_rst, 1);
        reg_wr(6'd5, 8'hFB);
        check("R9 vgen_rst clear", vgen_rst, 0);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        reg_rd(6'd7, v);
        repeat (3) @(negedge clk);
        check("R11 rdata held", host_rdata, 8'hA5);
        hwr(2'd3, 8'hEE);
        hrd(2'd3, v);
        check("R11 unused byte reads zero", v, 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_addr();
        t_write_read();
        t_no_flag();
        t_unimpl();
        t_select();
        t_strobe();
        t_vrst();
        t_hold();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule